// File: doc/BRIEF.md
# Multiprocessor Limit Timer Unit

This block provides one private tick timer for each processor plus a single shared system timer, all reachable through a small 32-bit register bus. Each timer holds a 21-bit up-counter and a 21-bit limit. The counter advances once per tick enable. When it has reached the limit, the next tick restarts it at 1 and latches a limit-reached flag. The flag drives an interrupt line that stays high until software acknowledges it.

Each processor's private timer drives only that processor's interrupt line, which is meant for the level-14 tick. The system timer drives one line that is fanned out to every processor as the level-10 tick. Software services an interrupt by reading the timer's limit register, which returns the flag and clears it. A second limit address lets software retune the period without losing a pending flag or disturbing the count. The processor count is a parameter, with up to 16 processors. Each timer has its own 4 KiB window.

Top module: `lt_timer_unit`

## Requirements
- R1: After synchronous reset, every private limit register reads 0x009c4000, the system limit register reads 0x00000000, all counts read zero, all flags are clear and every interrupt output is low.
- R2: Limit and count registers read with the flag in bit 31, the 21-bit value in bits 30:10 and zero in bits 9:0. On a write, only bits 30:10 are used; bit 31 and bits 9:0 are ignored.
- R3: Each cycle with `tick` high increments a timer's counter. If the counter already equals the limit, that tick sets it to 1 and sets the flag instead.
- R4: A write to the normal limit register (offset 0x0) loads the limit, zeroes the counter and clears the flag. It takes precedence over a tick in the same cycle.
- R5: A read of the normal limit register returns the flag and limit as they stood before the read, then clears the flag. A flag being set by a tick in the same cycle stays set.
- R6: A write to the no-clear limit register (offset 0x8) loads the limit and leaves the counter and the flag unchanged. A read of it returns flag and limit without clearing the flag.
- R7: `irq_cpu[i]` is high exactly while private timer i's flag is set, and `irq_sys` is high exactly while the system timer's flag is set. Both are levels, not pulses.
- R8: Private timer i occupies byte window i*0x1000 and the system timer occupies window 0x10000. Within a window, offset 0x0 is the limit, 0x4 the count (read-only) and 0x8 the no-clear limit. Any other offset or window reads as zero, and writes there or to a count have no effect.
- R9: A limit of zero means the full 21-bit range: the counter keeps counting past small values and sets no flag until it wraps at 0x1FFFFF.
- R10: `bus_rdata` is updated on the clock edge that samples `bus_rd` and holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled count enable shared by all timers |
| bus_addr | input | 17 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| irq_cpu | output | NUM_CPU | Per-processor private timer interrupts (level) |
| irq_sys | output | 1 | System timer interrupt, broadcast to all processors (level) |

## Verification
The hardest situation to reach from the ports is a collision in one clock edge: a wrap that sets the flag while a read of the limit register tries to clear it, or a tick arriving together with a limit write. The bench first brings a timer's counter exactly to its limit with a counted number of ticks. It then raises the read or write strobe in the same cycle as the next tick, and reads the count back to show which action won. A vector table covers the rest: retuning with the no-clear register while a flag is pending, and reads of the count, the limit and unmapped addresses.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int CNT_W    = 21;
  localparam int VAL_LSB  = 10;
  localparam int FLAG_BIT = 31;
  localparam int MAX_CPU  = 16;

  typedef enum logic [1:0] {
    REG_NONE  = 2'd0,
    REG_LIMIT = 2'd1,
    REG_COUNT = 2'd2,
    REG_LIMNC = 2'd3
  } reg_kind_e;

  function automatic logic [31:0] pack_word(input logic flag, input logic [CNT_W-1:0] val);
    return {flag, val, {VAL_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/lt_addr_decode.sv
module lt_addr_decode
  import lt_pkg::*;
#(
  parameter int NUM_CPU    = 4,
  parameter int PAGE_SHIFT = 12,
  parameter int ADDR_W     = PAGE_SHIFT + 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CPU:0]  sel,
  output reg_kind_e         kind
);
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

  logic [PAGE_W-1:0]     page;
  logic [PAGE_SHIFT-1:0] offs;

  assign page = addr[ADDR_W-1:PAGE_SHIFT];
  assign offs = addr[PAGE_SHIFT-1:0];

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_CPU; i++) begin
      if (page == PAGE_W'(i)) sel[i] = 1'b1;
    end
    if (page == PAGE_W'(MAX_CPU)) sel[NUM_CPU] = 1'b1;
  end

  always_comb begin
    case (offs)
      PAGE_SHIFT'(0): kind = REG_LIMIT;
      PAGE_SHIFT'(4): kind = REG_COUNT;
      PAGE_SHIFT'(8): kind = REG_LIMNC;
      default:        kind = REG_NONE;
    endcase
  end

  // R8
  always_comb begin
    onehot_sel_chk: assert ($onehot0(sel));
  end
endmodule

// File: rtl/lt_timer_core.sv
module lt_timer_core
  import lt_pkg::*;
#(
  parameter logic [CNT_W-1:0] RST_LIM = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_lim,
  input  logic             wr_nc,
  input  logic             rd_lim,
  input  logic [CNT_W-1:0] wval,
  output logic [CNT_W-1:0] lim,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  logic [CNT_W-1:0] end_val;
  logic             at_lim;

  assign end_val = (lim == '0) ? {CNT_W{1'b1}} : lim;
  assign at_lim  = (cnt == end_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      lim  <= RST_LIM;
      cnt  <= '0;
      flag <= 1'b0;
    end else if (wr_lim) begin
      lim  <= wval;
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (wr_nc) lim <= wval;
      if (tick) cnt <= at_lim ? CNT_W'(1) : cnt + CNT_W'(1);
      if (tick && at_lim) flag <= 1'b1;
      else if (rd_lim)    flag <= 1'b0;
    end
  end

  // R3
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && at_lim && !wr_lim) |=> (flag && cnt == CNT_W'(1)));
  // R3
  idle_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_lim) |=> $stable(cnt));
  // R4
  limit_write_clears_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lim |=> (cnt == '0 && !flag));
  // R6
  noclear_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_nc && !wr_lim && !tick && !rd_lim) |=> ($stable(flag) && $stable(cnt)));
  // R5
  read_acks_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_lim && !wr_lim && !(tick && at_lim)) |=> !flag);
endmodule

// File: rtl/lt_timer_unit.sv
module lt_timer_unit
  import lt_pkg::*;
#(
  parameter int NUM_CPU    = 4,
  parameter int PAGE_SHIFT = 12,
  parameter int ADDR_W     = PAGE_SHIFT + 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_CPU-1:0] irq_cpu,
  output logic               irq_sys
);
  localparam int NT = NUM_CPU + 1;
  localparam logic [CNT_W-1:0] CPU_RST_LIM = CNT_W'(10000);

  logic [NT-1:0]    sel;
  reg_kind_e        kind;
  logic [CNT_W-1:0] wval;
  logic [CNT_W-1:0] lim_a  [NT];
  logic [CNT_W-1:0] cnt_a  [NT];
  logic [NT-1:0]    flag_a;
  logic [31:0]      rd_word;
  logic             unused_wbits;

  assign wval         = bus_wdata[FLAG_BIT-1:VAL_LSB];
  assign unused_wbits = ^{bus_wdata[FLAG_BIT], bus_wdata[VAL_LSB-1:0]};

  lt_addr_decode #(
    .NUM_CPU(NUM_CPU), .PAGE_SHIFT(PAGE_SHIFT), .ADDR_W(ADDR_W)
  ) u_dec (
    .addr(bus_addr), .sel(sel), .kind(kind)
  );

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    localparam logic [CNT_W-1:0] RL = (i < NUM_CPU) ? CPU_RST_LIM : '0;
    lt_timer_core #(.RST_LIM(RL)) u_core (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .wr_lim (bus_wr && sel[i] && kind == REG_LIMIT),
      .wr_nc  (bus_wr && sel[i] && kind == REG_LIMNC),
      .rd_lim (bus_rd && sel[i] && kind == REG_LIMIT),
      .wval   (wval),
      .lim    (lim_a[i]),
      .cnt    (cnt_a[i]),
      .flag   (flag_a[i])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NT; i++) begin
      if (sel[i]) begin
        case (kind)
          REG_LIMIT, REG_LIMNC: rd_word = pack_word(flag_a[i], lim_a[i]);
          REG_COUNT:            rd_word = pack_word(flag_a[i], cnt_a[i]);
          default:              rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  assign irq_cpu = flag_a[NUM_CPU-1:0];
  assign irq_sys = flag_a[NUM_CPU];

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  // R2
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[VAL_LSB-1:0] == '0);
endmodule

// File: tb/lt_timer_unit_bench.sv
module lt_timer_unit_bench;
  localparam int NC = 4;

  typedef struct packed {
    logic [1:0]  op;
    logic [16:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam logic [1:0] WR = 2'd0, RD = 2'd1, TK = 2'd2, IQ = 2'd3;
  localparam int NV = 37;

  localparam vec_t TBL [NV] = '{
    '{RD, 17'h00000, 32'h0,        32'h009c4000, 4'd1},  // R1 private limit
    '{RD, 17'h10000, 32'h0,        32'h00000000, 4'd1},  // R1 system limit
    '{IQ, 17'h0,     32'h0,        32'h00000000, 4'd1},  // R1 irqs low
    '{WR, 17'h00000, 32'h00000C00, 32'h0,        4'd4},  // R4 limit 3
    '{TK, 17'h0,     32'd2,        32'h0,        4'd3},
    '{RD, 17'h00004, 32'h0,        32'h00000800, 4'd3},  // R3 count 2
    '{TK, 17'h0,     32'd1,        32'h0,        4'd3},
    '{RD, 17'h00004, 32'h0,        32'h00000C00, 4'd3},  // R3 count at limit
    '{TK, 17'h0,     32'd1,        32'h0,        4'd3},
    '{RD, 17'h00004, 32'h0,        32'h80000400, 4'd3},  // R3 wrapped to 1, flag
    '{IQ, 17'h0,     32'h0,        32'h00000001, 4'd7},  // R7 cpu0 irq level
    '{RD, 17'h00000, 32'h0,        32'h80000C00, 4'd5},  // R5 read returns flag
    '{RD, 17'h00000, 32'h0,        32'h00000C00, 4'd5},  // R5 flag cleared
    '{IQ, 17'h0,     32'h0,        32'h00000000, 4'd7},  // R7 irq dropped
    '{TK, 17'h0,     32'd3,        32'h0,        4'd3},
    '{WR, 17'h00008, 32'h00001400, 32'h0,        4'd6},  // R6 no-clear limit 5
    '{RD, 17'h00004, 32'h0,        32'h80000400, 4'd6},  // R6 count and flag kept
    '{RD, 17'h00008, 32'h0,        32'h80001400, 4'd6},  // R6 read no clear
    '{IQ, 17'h0,     32'h0,        32'h00000001, 4'd6},  // R6 irq still high
    '{TK, 17'h0,     32'd4,        32'h0,        4'd3},
    '{RD, 17'h00004, 32'h0,        32'h80001400, 4'd6},  // R6 new limit used
    '{WR, 17'h10000, 32'h00000800, 32'h0,        4'd4},  // R4 system limit 2
    '{TK, 17'h0,     32'd3,        32'h0,        4'd3},
    '{IQ, 17'h0,     32'h0,        32'h00000011, 4'd7},  // R7 system irq
    '{RD, 17'h10004, 32'h0,        32'h80000400, 4'd3},  // R3 system count
    '{RD, 17'h1000C, 32'h0,        32'h00000000, 4'd8},  // R8 unmapped offset
    '{WR, 17'h01004, 32'hFFFFFFFF, 32'h0,        4'd8},  // R8 count write ignored
    '{RD, 17'h01004, 32'h0,        32'h00003800, 4'd8},  // R8 cpu1 count 14
    '{RD, 17'h03000, 32'h0,        32'h009c4000, 4'd8},  // R8 cpu3 window
    '{RD, 17'h10000, 32'h0,        32'h80000800, 4'd5},  // R5 system ack
    '{IQ, 17'h0,     32'h0,        32'h00000001, 4'd7},  // R7 system irq dropped
    '{WR, 17'h00000, 32'h00000000, 32'h0,        4'd9},  // R9 limit zero
    '{TK, 17'h0,     32'd5,        32'h0,        4'd9},
    '{RD, 17'h00004, 32'h0,        32'h00001400, 4'd9},  // R9 no early wrap
    '{RD, 17'h04000, 32'h0,        32'h00000000, 4'd8},  // R8 absent cpu window
    '{WR, 17'h02000, 32'h80000FFF, 32'h0,        4'd2},  // R2 stray bits
    '{RD, 17'h02000, 32'h0,        32'h00000C00, 4'd2}   // R2 only 30:10 used
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic [16:0]   bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] irq_cpu;
  logic          irq_sys;
  int            n_run = 0;
  int            n_fail = 0;

  always #5 clk = ~clk;

  lt_timer_unit #(.NUM_CPU(NC)) u_lt_timer_unit (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_cpu(irq_cpu), .irq_sys(irq_sys)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [16:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [16:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic do_tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        WR: do_wr(TBL[i].addr, TBL[i].data);
        TK: do_tick(int'(TBL[i].data));
        RD: begin
          do_rd(TBL[i].addr, v);
          check($sformatf("R%0d vec%0d", TBL[i].req, i), v, TBL[i].exp);
        end
        default: begin
          @(negedge clk);
          check($sformatf("R%0d vec%0d irq", TBL[i].req, i),
                {27'd0, irq_sys, irq_cpu}, TBL[i].exp);
        end
      endcase
    end

    // R10: rdata holds over idle cycles
    held = bus_rdata;
    do_tick(2);
    check("R10 rdata hold", bus_rdata, held);

    // R4: limit write beats a same-cycle tick (cpu1)
    @(negedge clk); bus_addr = 17'h01000; bus_wdata = 32'h00000C00; bus_wr = 1'b1; tick = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tick = 1'b0;
    do_rd(17'h01004, v);
    check("R4 write over tick", v, 32'h00000000);

    // R5: wrap on the same edge as an acknowledging read keeps the flag
    do_tick(3);
    @(negedge clk); bus_addr = 17'h01000; bus_rd = 1'b1; tick = 1'b1;
    @(negedge clk); bus_rd = 1'b0; tick = 1'b0; v = bus_rdata;
    check("R5 read value on collision", v, 32'h00000C00);
    check("R5 flag survives collision", {31'd0, irq_cpu[1]}, 32'd1);
    do_rd(17'h01004, v);
    check("R5 count after collision", v, 32'h80000400);

    // R1: reset mid-run restores defaults
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 irqs after reset", {27'd0, irq_sys, irq_cpu}, 32'd0);
    do_rd(17'h01000, v);
    check("R1 limit after reset", v, 32'h009c4000);
    do_rd(17'h10004, v);
    check("R1 system count after reset", v, 32'h00000000);

    finish_up();
  end
endmodule